// File: doc/BRIEF.md
# Cache and TLB Invalidation Sequencer

This block carries out three maintenance operations on a small internal cache and a small translation buffer. It can drop every cache line without saving anything. It can copy every modified line out to memory and then drop every line. It can also remove the translation entries for one page. After either whole-cache operation it raises a one-cycle request toward the outer cache levels. That request is a plain invalidate after the first operation and a write-back-and-invalidate after the second.

The cache and the translation buffer are register arrays held inside the block. A fill port loads lines and a second fill port loads translation entries. Readback ports show the stored state, so that a surrounding test or model can observe it. The write-back operation visits the lines in ascending index order. For each line that is both valid and modified, it raises a memory request and holds it until memory acknowledges. Only then does it move to the next line.

A command is accepted only while the block is idle. From acceptance until the cycle after its done pulse, the block reports busy.

Top module: `cache_maint_seq`

## Requirements
- R1: After reset, busy, done, wb_req, ext_inv and ext_wbinv are low, and every cache line and every translation entry reads back as invalid.
- R2: Opcode 2'b01 (drop all) clears valid and dirty on every line and issues no memory write. Done rises exactly two cycles after the accepting clock edge, and ext_inv is high in the done cycle while ext_wbinv stays low.
- R3: Opcode 2'b10 (write back, then drop) issues exactly one memory write for each line that is valid and dirty. The writes come in ascending line index, with wb_addr = {tag, index} (index in the low bits) and wb_data = the line data. Clean or invalid lines are never written.
- R4: While wb_req is high and wb_ack is low, wb_req stays high and wb_addr and wb_data hold their values. No later line is requested before the acknowledge.
- R5: After the last write of opcode 2'b10, every line reads back invalid. ext_wbinv is high in the done cycle and ext_inv stays low.
- R6: Opcode 2'b11 (page flush) invalidates every translation entry whose page equals cmd_page and leaves the cache and all other entries unchanged. It issues no memory write and no outer-cache request, and done rises two cycles after acceptance.
- R7: A page flush whose page matches no valid entry completes with done and changes no stored state.
- R8: busy goes high on the edge that accepts a command and falls on the edge after done. A command presented while busy, or with opcode 2'b00, is ignored.
- R9: Writes on the line and translation fill ports are ignored while busy.
- R10: done, ext_inv and ext_wbinv are single-cycle pulses, and ext_inv and ext_wbinv are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 01 drop all, 10 write back then drop, 11 page flush, 00 none |
| cmd_page | input | PAGE_W | Page operand of the flush |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| line_wr_en | input | 1 | Load a cache line (marks it valid) |
| line_wr_idx | input | IDX_W | Line index to load |
| line_wr_tag | input | TAG_W | Tag to load |
| line_wr_data | input | DATA_W | Data to load |
| line_wr_dirty | input | 1 | Modified flag to load |
| line_rd_idx | input | IDX_W | Line readback index |
| line_rd_valid | output | 1 | Readback valid flag |
| line_rd_dirty | output | 1 | Readback modified flag |
| line_rd_tag | output | TAG_W | Readback tag |
| tlb_wr_en | input | 1 | Load a translation entry (marks it valid) |
| tlb_wr_slot | input | SLOT_W | Entry slot to load |
| tlb_wr_page | input | PAGE_W | Page to load |
| tlb_rd_slot | input | SLOT_W | Entry readback slot |
| tlb_rd_valid | output | 1 | Readback entry valid |
| tlb_rd_page | output | PAGE_W | Readback entry page |
| wb_req | output | 1 | Memory write request |
| wb_addr | output | TAG_W+IDX_W | Write address {tag, index} |
| wb_data | output | DATA_W | Write data |
| wb_ack | input | 1 | Memory write acknowledge |
| ext_inv | output | 1 | Outer caches: invalidate |
| ext_wbinv | output | 1 | Outer caches: write back and invalidate |

## Verification
The hardest situation to reach is a write-back walk in which the modified lines sit at both ends of the index range and are mixed with clean and invalid lines. Memory must also hold the acknowledge back for several cycles, while the bench tries to inject a fresh command and fill writes. The bench loads such a pattern directly, with line 0 and the last line dirty, and answers each request after a random delay. It then repeats with random line contents, random flags and random translation pages drawn from a small pool, so that duplicate page matches also occur.

// File: rtl/cmaint_pkg.sv
package cmaint_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_INV   = 2'b01,
        OP_WBINV = 2'b10,
        OP_TLBPG = 2'b11
    } maint_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_WBACK,
        ST_CLEAR,
        ST_TLB,
        ST_FIN
    } seq_state_e;

endpackage

// File: rtl/cmaint_line_store.sv
module cmaint_line_store #(
    parameter int NLINES = 16,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              fill_dirty,
    input  logic              clr_all,
    input  logic              clr_dirty_en,
    input  logic [IDX_W-1:0]  walk_idx,
    output logic              walk_valid,
    output logic              walk_dirty,
    output logic [TAG_W-1:0]  walk_tag,
    output logic [DATA_W-1:0] walk_data,
    input  logic [IDX_W-1:0]  peek_idx,
    output logic              peek_valid,
    output logic              peek_dirty,
    output logic [TAG_W-1:0]  peek_tag
);

    typedef struct packed {
        logic [NLINES-1:0]             valid;
        logic [NLINES-1:0]             dirty;
        logic [NLINES-1:0][TAG_W-1:0]  tag;
        logic [NLINES-1:0][DATA_W-1:0] data;
    } line_arr_t;

    line_arr_t q, d;

    always_comb begin
        d = q;
        if (fill_en) begin
            d.valid[fill_idx] = 1'b1;
            d.dirty[fill_idx] = fill_dirty;
            d.tag[fill_idx]   = fill_tag;
            d.data[fill_idx]  = fill_data;
        end
        if (clr_dirty_en) begin
            d.dirty[walk_idx] = 1'b0;
        end
        if (clr_all) begin
            d.valid = '0;
            d.dirty = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign walk_valid = q.valid[walk_idx];
    assign walk_dirty = q.dirty[walk_idx];
    assign walk_tag   = q.tag[walk_idx];
    assign walk_data  = q.data[walk_idx];
    assign peek_valid = q.valid[peek_idx];
    assign peek_dirty = q.dirty[peek_idx];
    assign peek_tag   = q.tag[peek_idx];

endmodule

// File: rtl/cmaint_tlb_store.sv
module cmaint_tlb_store #(
    parameter int NTLB   = 8,
    parameter int PAGE_W = 20,
    localparam int SLOT_W = $clog2(NTLB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_en,
    input  logic [SLOT_W-1:0] fill_slot,
    input  logic [PAGE_W-1:0] fill_page,
    input  logic              flush_en,
    input  logic [PAGE_W-1:0] flush_page,
    input  logic [SLOT_W-1:0] peek_slot,
    output logic              peek_valid,
    output logic [PAGE_W-1:0] peek_page
);

    typedef struct packed {
        logic [NTLB-1:0]             valid;
        logic [NTLB-1:0][PAGE_W-1:0] page;
    } tlb_arr_t;

    tlb_arr_t q, d;
    logic [NTLB-1:0] hit;

    for (genvar s = 0; s < NTLB; s++) begin : g_match
        assign hit[s] = q.valid[s] && (q.page[s] == flush_page);
    end

    always_comb begin
        d = q;
        if (fill_en) begin
            d.valid[fill_slot] = 1'b1;
            d.page[fill_slot]  = fill_page;
        end
        if (flush_en) begin
            d.valid = d.valid & ~hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign peek_valid = q.valid[peek_slot];
    assign peek_page  = q.page[peek_slot];

endmodule

// File: rtl/cmaint_seq_fsm.sv
module cmaint_seq_fsm
    import cmaint_pkg::*;
#(
    parameter int NLINES = 16,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 32,
    parameter int PAGE_W = 20,
    localparam int IDX_W  = $clog2(NLINES),
    localparam int ADDR_W = TAG_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [PAGE_W-1:0] cmd_page,
    output logic              busy,
    output logic              done,
    output logic              ext_inv,
    output logic              ext_wbinv,
    output logic [IDX_W-1:0]  walk_idx,
    input  logic              walk_valid,
    input  logic              walk_dirty,
    input  logic [TAG_W-1:0]  walk_tag,
    input  logic [DATA_W-1:0] walk_data,
    output logic              clr_all,
    output logic              clr_dirty,
    output logic              tlb_flush,
    output logic [PAGE_W-1:0] tlb_flush_page,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data,
    input  logic              wb_ack
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NLINES - 1);

    typedef struct packed {
        seq_state_e        st;
        maint_op_e         op;
        logic [PAGE_W-1:0] page;
        logic [IDX_W-1:0]  idx;
    } seq_regs_t;

    localparam seq_regs_t SEQ_RESET = '{st: ST_IDLE, op: OP_NONE, page: '0, idx: '0};

    seq_regs_t q, d;
    maint_op_e op_in;

    assign op_in = maint_op_e'(cmd_op);

    always_comb begin
        d         = q;
        clr_all   = 1'b0;
        clr_dirty = 1'b0;
        tlb_flush = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (cmd_valid && op_in != OP_NONE) begin
                    d.op   = op_in;
                    d.page = cmd_page;
                    d.idx  = '0;
                    unique case (op_in)
                        OP_INV:   d.st = ST_CLEAR;
                        OP_WBINV: d.st = ST_SCAN;
                        OP_TLBPG: d.st = ST_TLB;
                        default:  d.st = ST_IDLE;
                    endcase
                end
            end
            ST_SCAN: begin
                if (walk_valid && walk_dirty) begin
                    d.st = ST_WBACK;
                end else if (q.idx == LAST_IDX) begin
                    d.st = ST_CLEAR;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
            ST_WBACK: begin
                if (wb_ack) begin
                    clr_dirty = 1'b1;
                    if (q.idx == LAST_IDX) begin
                        d.st = ST_CLEAR;
                    end else begin
                        d.idx = q.idx + 1'b1;
                        d.st  = ST_SCAN;
                    end
                end
            end
            ST_CLEAR: begin
                clr_all = 1'b1;
                d.st    = ST_FIN;
            end
            ST_TLB: begin
                tlb_flush = 1'b1;
                d.st      = ST_FIN;
            end
            ST_FIN: begin
                d.st = ST_IDLE;
                d.op = OP_NONE;
            end
            default: d = SEQ_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SEQ_RESET;
        else        q <= d;
    end

    assign busy           = (q.st != ST_IDLE);
    assign done           = (q.st == ST_FIN);
    assign ext_inv        = done && (q.op == OP_INV);
    assign ext_wbinv      = done && (q.op == OP_WBINV);
    assign walk_idx       = q.idx;
    assign tlb_flush_page = q.page;
    assign wb_req         = (q.st == ST_WBACK);
    assign wb_addr        = {walk_tag, q.idx};
    assign wb_data        = walk_data;

endmodule

// File: rtl/cache_maint_seq.sv
module cache_maint_seq #(
    parameter int NLINES = 16,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 32,
    parameter int PAGE_W = 20,
    parameter int NTLB   = 8,
    localparam int IDX_W  = $clog2(NLINES),
    localparam int SLOT_W = $clog2(NTLB),
    localparam int ADDR_W = TAG_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [PAGE_W-1:0] cmd_page,
    output logic              busy,
    output logic              done,
    input  logic              line_wr_en,
    input  logic [IDX_W-1:0]  line_wr_idx,
    input  logic [TAG_W-1:0]  line_wr_tag,
    input  logic [DATA_W-1:0] line_wr_data,
    input  logic              line_wr_dirty,
    input  logic [IDX_W-1:0]  line_rd_idx,
    output logic              line_rd_valid,
    output logic              line_rd_dirty,
    output logic [TAG_W-1:0]  line_rd_tag,
    input  logic              tlb_wr_en,
    input  logic [SLOT_W-1:0] tlb_wr_slot,
    input  logic [PAGE_W-1:0] tlb_wr_page,
    input  logic [SLOT_W-1:0] tlb_rd_slot,
    output logic              tlb_rd_valid,
    output logic [PAGE_W-1:0] tlb_rd_page,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data,
    input  logic              wb_ack,
    output logic              ext_inv,
    output logic              ext_wbinv
);

    logic [IDX_W-1:0]  walk_idx;
    logic              walk_valid;
    logic              walk_dirty;
    logic [TAG_W-1:0]  walk_tag;
    logic [DATA_W-1:0] walk_data;
    logic              clr_all;
    logic              clr_dirty;
    logic              tlb_flush;
    logic [PAGE_W-1:0] tlb_flush_page;
    logic              line_fill_ok;
    logic              tlb_fill_ok;

    assign line_fill_ok = line_wr_en && !busy;
    assign tlb_fill_ok  = tlb_wr_en && !busy;

    cmaint_seq_fsm #(
        .NLINES(NLINES), .TAG_W(TAG_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_page(cmd_page),
        .busy(busy), .done(done), .ext_inv(ext_inv), .ext_wbinv(ext_wbinv),
        .walk_idx(walk_idx), .walk_valid(walk_valid), .walk_dirty(walk_dirty),
        .walk_tag(walk_tag), .walk_data(walk_data),
        .clr_all(clr_all), .clr_dirty(clr_dirty),
        .tlb_flush(tlb_flush), .tlb_flush_page(tlb_flush_page),
        .wb_req(wb_req), .wb_addr(wb_addr), .wb_data(wb_data), .wb_ack(wb_ack)
    );

    cmaint_line_store #(
        .NLINES(NLINES), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_lines (
        .clk(clk), .rst_n(rst_n),
        .fill_en(line_fill_ok), .fill_idx(line_wr_idx), .fill_tag(line_wr_tag),
        .fill_data(line_wr_data), .fill_dirty(line_wr_dirty),
        .clr_all(clr_all), .clr_dirty_en(clr_dirty),
        .walk_idx(walk_idx), .walk_valid(walk_valid), .walk_dirty(walk_dirty),
        .walk_tag(walk_tag), .walk_data(walk_data),
        .peek_idx(line_rd_idx), .peek_valid(line_rd_valid),
        .peek_dirty(line_rd_dirty), .peek_tag(line_rd_tag)
    );

    cmaint_tlb_store #(
        .NTLB(NTLB), .PAGE_W(PAGE_W)
    ) u_tlb (
        .clk(clk), .rst_n(rst_n),
        .fill_en(tlb_fill_ok), .fill_slot(tlb_wr_slot), .fill_page(tlb_wr_page),
        .flush_en(tlb_flush), .flush_page(tlb_flush_page),
        .peek_slot(tlb_rd_slot), .peek_valid(tlb_rd_valid), .peek_page(tlb_rd_page)
    );

endmodule

// File: rtl/cache_maint_seq_chk.sv
module cache_maint_seq_chk #(
    parameter int IDX_W  = 4,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic              busy,
    input logic              done,
    input logic              ext_inv,
    input logic              ext_wbinv,
    input logic              wb_req,
    input logic              wb_ack,
    input logic [ADDR_W-1:0] wb_addr,
    input logic [DATA_W-1:0] wb_data
);

    logic [IDX_W-1:0] last_idx_q;
    logic             have_last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_idx_q  <= '0;
            have_last_q <= 1'b0;
        end else if (done) begin
            have_last_q <= 1'b0;
        end else if (wb_req && wb_ack) begin
            last_idx_q  <= wb_addr[IDX_W-1:0];
            have_last_q <= 1'b1;
        end
    end

    a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(wb_req) && have_last_q) |-> (wb_addr[IDX_W-1:0] > last_idx_q));

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack) |=> (wb_req && $stable(wb_addr) && $stable(wb_data)));

    a_r8_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && cmd_op != 2'b00) |=> busy);

    a_r8_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_ext_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_inv && ext_wbinv));

    a_r2_ext_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_inv || ext_wbinv) |-> done);

endmodule

bind cache_maint_seq cache_maint_seq_chk #(
    .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .busy(busy), .done(done), .ext_inv(ext_inv), .ext_wbinv(ext_wbinv),
    .wb_req(wb_req), .wb_ack(wb_ack), .wb_addr(wb_addr), .wb_data(wb_data)
);

// File: tb/cache_maint_seq_test.sv
module cache_maint_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int NL     = 16;
    localparam int TAG_W  = 8;
    localparam int DATA_W = 32;
    localparam int PAGE_W = 20;
    localparam int NT     = 8;
    localparam int IDX_W  = $clog2(NL);
    localparam int SLOT_W = $clog2(NT);
    localparam int ADDR_W = TAG_W + IDX_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_op = 2'b00;
    logic [PAGE_W-1:0] cmd_page = '0;
    logic              busy, done;
    logic              line_wr_en = 1'b0;
    logic [IDX_W-1:0]  line_wr_idx = '0;
    logic [TAG_W-1:0]  line_wr_tag = '0;
    logic [DATA_W-1:0] line_wr_data = '0;
    logic              line_wr_dirty = 1'b0;
    logic [IDX_W-1:0]  line_rd_idx = '0;
    logic              line_rd_valid, line_rd_dirty;
    logic [TAG_W-1:0]  line_rd_tag;
    logic              tlb_wr_en = 1'b0;
    logic [SLOT_W-1:0] tlb_wr_slot = '0;
    logic [PAGE_W-1:0] tlb_wr_page = '0;
    logic [SLOT_W-1:0] tlb_rd_slot = '0;
    logic              tlb_rd_valid;
    logic [PAGE_W-1:0] tlb_rd_page;
    logic              wb_req;
    logic [ADDR_W-1:0] wb_addr;
    logic [DATA_W-1:0] wb_data;
    logic              wb_ack = 1'b0;
    logic              ext_inv, ext_wbinv;

    cache_maint_seq #(
        .NLINES(NL), .TAG_W(TAG_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W), .NTLB(NT)
    ) uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_errs   = 0;

    bit              m_valid [NL];
    bit              m_dirty [NL];
    logic [TAG_W-1:0]  m_tag [NL];
    logic [DATA_W-1:0] m_data [NL];
    bit              t_valid [NT];
    logic [PAGE_W-1:0] t_page [NT];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int pool_page(input int k);
        return 32'h10 + k;
    endfunction

    task automatic fill_line(input int idx, input logic [TAG_W-1:0] tag,
                             input logic [DATA_W-1:0] data, input bit dirty);
        line_wr_en = 1'b1; line_wr_idx = IDX_W'(idx); line_wr_tag = tag;
        line_wr_data = data; line_wr_dirty = dirty;
        @(negedge clk);
        line_wr_en = 1'b0;
        m_valid[idx] = 1; m_dirty[idx] = dirty; m_tag[idx] = tag; m_data[idx] = data;
    endtask

    task automatic fill_tlb(input int slot, input logic [PAGE_W-1:0] page);
        tlb_wr_en = 1'b1; tlb_wr_slot = SLOT_W'(slot); tlb_wr_page = page;
        @(negedge clk);
        tlb_wr_en = 1'b0;
        t_valid[slot] = 1; t_page[slot] = page;
    endtask

    task automatic check_state(input string req);
        for (int i = 0; i < NL; i++) begin
            line_rd_idx = IDX_W'(i);
            #1;
            check(line_rd_valid == m_valid[i], req, $sformatf("line %0d valid", i),
                  line_rd_valid, m_valid[i]);
            if (m_valid[i]) begin
                check(line_rd_dirty == m_dirty[i], req, $sformatf("line %0d dirty", i),
                      line_rd_dirty, m_dirty[i]);
                check(line_rd_tag == m_tag[i], req, $sformatf("line %0d tag", i),
                      line_rd_tag, m_tag[i]);
            end
        end
        for (int s = 0; s < NT; s++) begin
            tlb_rd_slot = SLOT_W'(s);
            #1;
            check(tlb_rd_valid == t_valid[s], req, $sformatf("tlb %0d valid", s),
                  tlb_rd_valid, t_valid[s]);
            if (t_valid[s])
                check(tlb_rd_page == t_page[s], req, $sformatf("tlb %0d page", s),
                      tlb_rd_page, t_page[s]);
        end
        @(negedge clk);
    endtask

    task automatic run_cmd(input logic [1:0] op, input logic [PAGE_W-1:0] page,
                           input int max_delay, input bit poke, input string req);
        logic [ADDR_W-1:0] exp_addr[$];
        logic [DATA_W-1:0] exp_data[$];
        int k = 0;
        int cycles = 0;
        int wait_n = 0;
        int n_done = 0;
        if (op == 2'b10)
            for (int i = 0; i < NL; i++)
                if (m_valid[i] && m_dirty[i]) begin
                    exp_addr.push_back({m_tag[i], IDX_W'(i)});
                    exp_data.push_back(m_data[i]);
                end
        cmd_valid = 1'b1; cmd_op = op; cmd_page = page;
        @(negedge clk);
        cmd_valid = 1'b0;
        cycles = 1;
        check(busy == 1'b1, "R8", "busy after accept", busy, 1);
        if (poke) begin
            cmd_valid = 1'b1; cmd_op = 2'b01;
            line_wr_en = 1'b1; line_wr_idx = IDX_W'(NL - 2); line_wr_dirty = 1'b1;
            line_wr_tag = 8'h5A; line_wr_data = 32'hDEAD_BEEF;
            tlb_wr_en = 1'b1; tlb_wr_slot = '0; tlb_wr_page = 20'hABCDE;
        end
        wait_n = (max_delay > 0) ? int'($urandom % (max_delay + 1)) : 0;
        while (!done && cycles < 5000) begin
            if (wb_ack) wb_ack = 1'b0;
            if (op != 2'b10)
                check(wb_req == 1'b0, (op == 2'b01) ? "R2" : "R6", "no writeback", wb_req, 0);
            if (wb_req) begin
                if (k < exp_addr.size()) begin
                    check(wb_addr == exp_addr[k], "R4", "wb_addr", wb_addr, exp_addr[k]);
                    check(wb_data == exp_data[k], "R4", "wb_data", wb_data, exp_data[k]);
                end else begin
                    check(1'b0, "R3", "extra writeback", k, exp_addr.size());
                end
                if (wait_n > 0) begin
                    wait_n--;
                end else begin
                    wb_ack = 1'b1;
                    k++;
                    wait_n = (max_delay > 0) ? int'($urandom % (max_delay + 1)) : 0;
                end
            end
            @(negedge clk);
            if (poke) begin
                cmd_valid = 1'b0; line_wr_en = 1'b0; tlb_wr_en = 1'b0; poke = 0;
            end
            cycles++;
        end
        wb_ack = 1'b0;
        check(done == 1'b1, req, "done seen", done, 1);
        n_done = 1;
        check(ext_inv == (op == 2'b01), (op == 2'b10) ? "R5" : req, "ext_inv", ext_inv, op == 2'b01);
        check(ext_wbinv == (op == 2'b10), (op == 2'b10) ? "R5" : req, "ext_wbinv",
              ext_wbinv, op == 2'b10);
        if (op == 2'b10)
            check(k == exp_addr.size(), "R3", "writeback count", k, exp_addr.size());
        else
            check(cycles == 2, req, "latency to done", cycles, 2);
        @(negedge clk);
        check(done == 1'b0 && ext_inv == 1'b0 && ext_wbinv == 1'b0, "R10",
              "pulses one cycle", {done, ext_inv, ext_wbinv}, 0);
        check(busy == 1'b0, "R8", "busy released", busy, n_done - 1);
        if (op == 2'b01 || op == 2'b10)
            for (int i = 0; i < NL; i++) begin m_valid[i] = 0; m_dirty[i] = 0; end
        else
            for (int s = 0; s < NT; s++) if (t_valid[s] && t_page[s] == page) t_valid[s] = 0;
        check_state((op == 2'b10) ? "R5" : req);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_errs++;
        n_checks++;
        $display("FAIL R8 watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NL; i++) begin m_valid[i] = 0; m_dirty[i] = 0; m_tag[i] = '0; m_data[i] = '0; end
        for (int s = 0; s < NT; s++) begin t_valid[s] = 0; t_page[s] = '0; end
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && wb_req == 0 && ext_inv == 0 && ext_wbinv == 0,
              "R1", "outputs in reset", {busy, done, wb_req, ext_inv, ext_wbinv}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_state("R1");

        // R8: opcode 00 ignored
        cmd_valid = 1'b1; cmd_op = 2'b00;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(busy == 1'b0 && done == 1'b0, "R8", "op 00 ignored", busy, 0);

        // R3/R4/R5/R9: dirty lines at both ends, mixed with clean ones, slow acks, poke while busy
        fill_line(0, 8'hA0, 32'h1111_0000, 1);
        fill_line(3, 8'hA3, 32'h3333_0000, 0);
        fill_line(7, 8'hA7, 32'h7777_0000, 1);
        fill_line(NL - 1, 8'hAF, 32'hFFFF_0000, 1);
        fill_tlb(2, 20'h00042);
        run_cmd(2'b10, '0, 4, 1, "R3");

        // R6: duplicate page matches, line fill poke ignored (R9)
        fill_line(5, 8'h55, 32'h5555_0000, 1);
        fill_tlb(1, pool_page(1));
        fill_tlb(4, pool_page(1));
        fill_tlb(6, pool_page(2));
        run_cmd(2'b11, pool_page(1), 0, 1, "R6");

        // R7: no matching page
        run_cmd(2'b11, 20'h99999, 0, 0, "R7");

        // R2: drop all with dirty lines present
        fill_line(9, 8'h99, 32'h9999_0000, 1);
        run_cmd(2'b01, '0, 0, 0, "R2");

        // R3: write back on an empty cache
        run_cmd(2'b10, '0, 2, 0, "R3");

        // random rounds
        for (int r = 0; r < 10; r++) begin
            for (int i = 0; i < NL; i++)
                if ($urandom % 3 != 0)
                    fill_line(i, TAG_W'($urandom), $urandom, 1'($urandom));
            for (int s = 0; s < NT; s++)
                if ($urandom % 2 != 0)
                    fill_tlb(s, pool_page(int'($urandom % 4)));
            begin
                logic [1:0] op;
                op = 2'(1 + ($urandom % 3));
                run_cmd(op, pool_page(int'($urandom % 5)), int'($urandom % 5),
                        1'($urandom), (op == 2'b01) ? "R2" : (op == 2'b10) ? "R3" : "R6");
            end
        end

        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule